// File: doc/BRIEF.md
# Register Front End for a Byte UART

The block is the bus-side register file of a simple UART. A host reaches four word registers through a plain read/write port: receive data, transmit data, status and control. Bytes arriving from a serial receiver enter through a valid/ready byte stream and are held in an eight-entry receive queue. The host drains that queue by reading the receive-data register.

Bytes written to the transmit-data register leave at once on a byte stream output. That output never stalls, so the transmit side always reports empty. A sticky pending flag and an enable bit in the control word drive one level interrupt. The pending flag is set by waiting receive data or by a transmit write, and a status read clears it.

Serial bit timing, framing and error detection lie outside the block. The framing and parity status fields always read zero.

Top module: `byte_uart_csr`

## Requirements
- R1: Register select is byte-address bits [3:2] (0 receive data, 1 transmit data, 2 status, 3 control); bits [1:0] are ignored. The control register reads back the whole word last written, and the transmit register reads back the whole word last written to it.
- R2: Status layout: bit0 receive data available, bit1 receive queue full, bit2 transmit empty (always 1), bit3 transmit full (always 0), bit4 interrupt pending, bit5 overrun, bit6 and bit7 always 0, upper bits 0.
- R3: The receive queue holds up to 8 bytes and returns them oldest first; each receive-data read of a non-empty queue removes one byte.
- R4: `rx_ready` is low exactly while 8 bytes are held. A byte offered while the queue is full is discarded, and this sets the overrun bit.
- R5: A receive-data read while the queue is empty returns 0 and leaves the queue empty.
- R6: Writing control with bit1 set empties the queue and clears overrun. A byte accepted in that same cycle becomes the only entry.
- R7: A transmit-data write drives its low 8 bits on `tx_data` with `tx_valid` high for exactly the one cycle after the write.
- R8: The pending bit is set by any transmit write and whenever the queue holds data after a cycle. A status read returns the pending value from before the read and clears it unless the queue is non-empty after that cycle.
- R9: `irq` is high exactly when the pending bit and control bit4 are both 1.
- R10: A write to the status register changes no state and emits nothing.
- R11: A receive-data read and an accepted incoming byte in the same cycle keep the count unchanged and preserve order.
- R12: After reset the queue is empty, control, pending and overrun are 0, and status reads 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Byte address; bits [3:2] select a register |
| bus_rd | input | 1 | Read strobe; read data valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue can accept a byte |
| tx_valid | output | 1 | One-cycle pulse per transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
The sharpest collision occurs when the receive queue is popped by a host read and refilled by an incoming byte on the same clock edge. The bench drives the read strobe and `rx_valid` in one cycle, first with a part-filled queue and then with a full one. It expects the count to hold and the order to be kept in the first case. In the second it expects the offered byte to be dropped and overrun to be set. A second collision puts a flush write and an incoming byte in one cycle, and the bench expects that byte to be the only one left.

// File: rtl/bucsr_pkg.sv
package bucsr_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        REG_RXDATA  = 2'd0,
        REG_TXDATA  = 2'd1,
        REG_STATUS  = 2'd2,
        REG_CONTROL = 2'd3
    } reg_sel_e;

    localparam int CTL_TX_CLR = 0;
    localparam int CTL_RX_CLR = 1;
    localparam int CTL_IRQ_EN = 4;

    typedef struct packed {
        logic parity_err;
        logic frame_err;
        logic overrun;
        logic pending;
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_avail;
    } stat_t;

    typedef struct packed {
        logic rx_rd;
        logic tx_wr;
        logic stat_rd;
        logic ctrl_wr;
    } strobe_t;

    function automatic logic [WORD_W-1:0] stat_word(input stat_t s);
        return {{(WORD_W-BYTE_W){1'b0}}, s};
    endfunction
endpackage

// File: rtl/bucsr_decode.sv
module bucsr_decode
    import bucsr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_e          sel,
    output strobe_t           stb
);
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[1:0]};

    generate
        if (ADDR_W > 4) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:4];
        end
    endgenerate

    assign sel = reg_sel_e'(addr[3:2]);

    always_comb begin
        stb         = '0;
        stb.rx_rd   = rd && (sel == REG_RXDATA);
        stb.stat_rd = rd && (sel == REG_STATUS);
        stb.tx_wr   = wr && (sel == REG_TXDATA);
        stb.ctrl_wr = wr && (sel == REG_CONTROL);
    end
endmodule

// File: rtl/bucsr_rx_fifo.sv
module bucsr_rx_fifo #(
    parameter int DEPTH  = 8,
    parameter int BYTE_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_nxt,
    output logic              dropped
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W-1:0]  wr_idx;
    logic              full, push, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full     = (count == CNT_W'(DEPTH));
    assign in_ready = !full;
    assign push     = in_valid && !full;
    assign pop_ok   = pop && (count != '0);
    assign dropped  = in_valid && full;
    assign head     = mem[rd_ptr];
    assign wr_idx   = flush ? '0 : wr_ptr;

    always_comb begin
        if (flush)
            count_nxt = push ? CNT_W'(1) : '0;
        else
            count_nxt = count + CNT_W'(push) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_idx] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_nxt;
            if (flush) begin
                rd_ptr <= '0;
                wr_ptr <= push ? ptr_inc('0) : '0;
            end else begin
                if (push)
                    wr_ptr <= ptr_inc(wr_ptr);
                if (pop_ok)
                    rd_ptr <= ptr_inc(rd_ptr);
            end
        end
    end
endmodule

// File: rtl/bucsr_status_ctl.sv
module bucsr_status_ctl
    import bucsr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  count_nxt,
    input  logic              full,
    input  logic              dropped,
    output logic              flush,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] txreg_q,
    output stat_t             status,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);
    logic pend_q, ovr_q;

    assign flush = stb.ctrl_wr && wdata[CTL_RX_CLR];

    always_comb begin
        status            = '0;
        status.rx_avail   = (count != '0);
        status.rx_full    = full;
        status.tx_empty   = 1'b1;
        status.tx_full    = 1'b0;
        status.pending    = pend_q;
        status.overrun    = ovr_q;
        status.frame_err  = 1'b0;
        status.parity_err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            txreg_q  <= '0;
            pend_q   <= 1'b0;
            ovr_q    <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            if (stb.ctrl_wr)
                ctrl_q <= wdata;
            if (stb.tx_wr) begin
                txreg_q <= wdata;
                tx_data <= wdata[BYTE_W-1:0];
            end
            tx_valid <= stb.tx_wr;
            pend_q   <= stb.tx_wr || (count_nxt != '0) || (pend_q && !stb.stat_rd);
            if (flush)
                ovr_q <= 1'b0;
            else if (dropped)
                ovr_q <= 1'b1;
        end
    end

    assign irq = pend_q && ctrl_q[CTL_IRQ_EN];
endmodule

// File: rtl/byte_uart_csr.sv
module byte_uart_csr
    import bucsr_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int ADDR_W   = 4,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_data,
    output logic                  rx_ready,
    output logic                  tx_valid,
    output logic [BYTE_W-1:0]     tx_data,
    output logic                  irq
);
    reg_sel_e          sel;
    strobe_t           stb;
    logic              flush, dropped;
    logic [BYTE_W-1:0] head;
    logic [CNT_W-1:0]  rx_count, rx_count_nxt;
    logic [WORD_W-1:0] ctrl_word, txreg;
    stat_t             status;
    logic [WORD_W-1:0] mux;

    bucsr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .sel  (sel),
        .stb  (stb)
    );

    bucsr_rx_fifo #(.DEPTH(RX_DEPTH), .BYTE_W(BYTE_W)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .in_valid  (rx_valid),
        .in_data   (rx_data),
        .in_ready  (rx_ready),
        .pop       (stb.rx_rd),
        .head      (head),
        .count     (rx_count),
        .count_nxt (rx_count_nxt),
        .dropped   (dropped)
    );

    bucsr_status_ctl #(.CNT_W(CNT_W)) ctl_i (
        .clk       (clk),
        .rst       (rst),
        .stb       (stb),
        .wdata     (bus_wdata),
        .count     (rx_count),
        .count_nxt (rx_count_nxt),
        .full      (!rx_ready),
        .dropped   (dropped),
        .flush     (flush),
        .ctrl_q    (ctrl_word),
        .txreg_q   (txreg),
        .status    (status),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .irq       (irq)
    );

    always_comb begin
        unique case (sel)
            REG_RXDATA:  mux = (rx_count != '0) ? {{(WORD_W-BYTE_W){1'b0}}, head} : '0;
            REG_TXDATA:  mux = txreg;
            REG_STATUS:  mux = stat_word(status);
            REG_CONTROL: mux = ctrl_word;
            default:     mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? mux : '0;
endmodule

// File: rtl/bucsr_chk.sv
module bucsr_chk #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              irq,
    input logic [CNT_W-1:0]  fill,
    input logic [31:0]       ctl_word
);
    logic [1:0] sel;
    assign sel = bus_addr[3:2];

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH)); // R3

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (fill == CNT_W'(DEPTH)) |-> !rx_ready); // R4

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == 2'd0 && fill == '0) |-> (bus_rdata == '0)); // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == 2'd3 && bus_wdata[1] && !rx_valid) |=> (fill == '0)); // R6

    AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == 2'd1) |=> (tx_valid && tx_data == $past(bus_wdata[7:0]))); // R7

    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel == 2'd1) |=> !tx_valid); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !ctl_word[4] |-> !irq); // R9

    AST_TX_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == 2'd1 && ctl_word[4]) |=> irq); // R8

    AST_STATUS_WR_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == 2'd2 && !bus_rd && !rx_valid) |=> ($stable(fill) && $stable(ctl_word))); // R10

    AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready && bus_rd && sel == 2'd0 && fill != '0 && !bus_wr) |=> $stable(fill)); // R11
endmodule

bind byte_uart_csr bucsr_chk #(.DEPTH(RX_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .irq       (irq),
    .fill      (rx_count),
    .ctl_word  (ctrl_word)
);

// File: tb/byte_uart_csr_tb_top.sv
module byte_uart_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        rx_valid, rx_ready;
    logic [7:0]  rx_data;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    always #4 clk = ~clk;

    byte_uart_csr dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [7:0]  mq[$];
    logic [7:0]  txq[$];
    logic        m_pend = 0, m_ovr = 0;
    logic [31:0] m_ctrl = 0, m_tx = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        return {24'd0, 2'b00, m_ovr, m_pend, 1'b0, 1'b1,
                (mq.size() == 8), (mq.size() != 0)};
    endfunction

    // Scoreboard monitor: each tx pulse must match the oldest expected byte (R7)
    always @(negedge clk) begin
        if (!rst && tx_valid) begin
            n_chk++;
            if (txq.size() == 0) begin
                n_fail++;
                $display("FAIL R7: actual tx %h expected no pulse", tx_data);
            end else begin
                logic [7:0] e;
                e = txq.pop_front();
                if (tx_data !== e) begin
                    n_fail++;
                    $display("FAIL R7: actual tx %h expected %h", tx_data, e);
                end
            end
        end
    end

    // One bus/stream cycle, called at a falling edge; checks read data and ready
    task automatic cyc(input string req, input logic rd, input logic wr, input logic [3:0] a,
                       input logic [31:0] wd, input logic rv, input logic [7:0] rb);
        logic [1:0]  s;
        logic [31:0] er;
        logic        full, acc, drop, pop, fl;
        s = a[3:2];
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        rx_valid = rv; rx_data = rb;
        case (s)
            2'd0: er = (mq.size() != 0) ? {24'd0, mq[0]} : 32'd0;
            2'd1: er = m_tx;
            2'd2: er = m_status();
            default: er = m_ctrl;
        endcase
        full = (mq.size() == 8);
        #1;
        if (rd) chk(req, bus_rdata, er);
        if (rv) chk("R4 ready", {31'd0, rx_ready}, {31'd0, !full});
        acc  = rv && !full;
        drop = rv && full;
        pop  = rd && s == 2'd0 && mq.size() != 0;
        fl   = wr && s == 2'd3 && wd[1];
        if (wr && s == 2'd3) m_ctrl = wd;
        if (wr && s == 2'd1) begin m_tx = wd; txq.push_back(wd[7:0]); end
        if (fl) begin
            mq.delete();
            if (acc) mq.push_back(rb);
            m_ovr = 0;
        end else begin
            if (pop) void'(mq.pop_front());
            if (acc) mq.push_back(rb);
            if (drop) m_ovr = 1;
        end
        m_pend = (m_pend && !(rd && s == 2'd2)) || (wr && s == 2'd1) || (mq.size() != 0);
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; rx_valid = 0;
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
        cyc("", 1'b0, 1'b1, {s, 2'b00}, d, 1'b0, 8'h00);
    endtask
    task automatic rd_reg(input string req, input logic [1:0] s);
        cyc(req, 1'b1, 1'b0, {s, 2'b00}, 32'd0, 1'b0, 8'h00);
    endtask
    task automatic offer(input logic [7:0] b);
        cyc("", 1'b0, 1'b0, 4'd0, 32'd0, 1'b1, b);
    endtask
    task automatic chk_irq(input string req);
        chk(req, {31'd0, irq}, {31'd0, m_pend && m_ctrl[4]});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0; rx_valid = 0; rx_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        chk("R12 irq", {31'd0, irq}, 32'd0);
        chk("R12 ready", {31'd0, rx_ready}, 32'd1);
        rd_reg("R12 status", 2'd2);
        chk("R12 status const", m_status(), 32'h4);
        rd_reg("R12 ctrl", 2'd3);
        // R1 decode and readback, low address bits ignored
        cyc("", 1'b0, 1'b1, 4'b1111, 32'hABCD_0010, 1'b0, 8'h00);
        cyc("R1 ctrl readback", 1'b1, 1'b0, 4'b1110, 32'd0, 1'b0, 8'h00);
        wr_reg(2'd3, 32'h0);
        // R7 tx write, R1 tx readback, R8 pending set and cleared by status read
        cyc("", 1'b0, 1'b1, 4'b0110, 32'h1234_56AB, 1'b0, 8'h00);
        chk_irq("R9 masked");
        cyc("R1 tx readback", 1'b1, 1'b0, 4'b0101, 32'd0, 1'b0, 8'h00);
        rd_reg("R8 status pend set", 2'd2);
        rd_reg("R8 status pend cleared", 2'd2);
        // R9 enabled interrupt driven by rx data
        wr_reg(2'd3, 32'h10);
        chk_irq("R9 idle");
        offer(8'h11);
        chk_irq("R9 rx raises");
        rd_reg("R8 status nonempty", 2'd2);
        rd_reg("R8 status stays", 2'd2);
        chk_irq("R9 held");
        rd_reg("R3 pop", 2'd0);
        rd_reg("R8 status after drain", 2'd2);
        chk_irq("R9 cleared");
        // R4 fill, drop and overrun; R3 order
        for (int i = 0; i < 8; i++) offer(8'h40 + 8'(i));
        chk("R4 not ready", {31'd0, rx_ready}, 32'd0);
        offer(8'hEE);
        rd_reg("R4 R2 status full ovr", 2'd2);
        for (int i = 0; i < 8; i++) rd_reg("R3 order", 2'd0);
        // R5 empty read
        rd_reg("R5 empty read", 2'd0);
        rd_reg("R5 status empty", 2'd2);
        // R10 status write ignored
        wr_reg(2'd2, 32'hFFFF_FFFF);
        rd_reg("R10 status unchanged", 2'd2);
        rd_reg("R10 ctrl unchanged", 2'd3);
        // R6 flush
        offer(8'h01); offer(8'h02); offer(8'h03);
        wr_reg(2'd3, 32'h12);
        rd_reg("R6 flushed status", 2'd2);
        rd_reg("R6 empty after flush", 2'd0);
        offer(8'h05);
        cyc("", 1'b0, 1'b1, 4'b1100, 32'h12, 1'b1, 8'h77);
        rd_reg("R6 same-cycle byte", 2'd0);
        rd_reg("R6 then empty", 2'd0);
        // R11 simultaneous pop and push
        offer(8'hA1); offer(8'hB2);
        cyc("R11 pop head", 1'b1, 1'b0, 4'b0000, 32'd0, 1'b1, 8'hC3);
        rd_reg("R11 second", 2'd0);
        rd_reg("R11 third", 2'd0);
        rd_reg("R11 status", 2'd2);
        // R4 R11 full queue read with offer: offered byte dropped
        for (int i = 0; i < 8; i++) offer(8'h60 + 8'(i));
        cyc("R11 full pop", 1'b1, 1'b0, 4'b0000, 32'd0, 1'b1, 8'hDD);
        rd_reg("R4 ovr after full collide", 2'd2);
        for (int i = 0; i < 7; i++) rd_reg("R3 drain", 2'd0);
        rd_reg("R5 drained", 2'd0);
        repeat (2) @(negedge clk);
        chk("R7 all tx seen", txq.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule